// File: doc/BRIEF.md
# Secondary Bus Reset Sequencer

This block steps a multi-port switch through a secondary bus reset. It handles two forms. An upstream request resets every downstream port. A downstream request resets a single port. A request starts on the rising edge of its control bit. The sequencer then performs four tasks:

- it raises a hot-reset request to the link layer of each port whose link is up;
- it pulses soft resets into the register file and the port logic;
- it flushes the queued packets of the affected ports through a done handshake;
- it waits for the control bit to fall, then returns to idle.

While a sequence runs, the block flags packets that target the secondary side of the affected bridge as unsupported requests. During an upstream sequence it also masks sideband register traffic. A sideband read of a resettable register returns zero, and a sideband write to such a register is dropped. Sticky and lockable registers are identified by the `sb_tgt_rst` input being low, and their sideband traffic passes unchanged. Configuration traffic to the upstream port is never touched.

Link training, the register storage and the packet queues are outside the block. They connect through the hot-reset acknowledge port, the soft-reset pulses and the flush handshake.

Top module: `sbr_seq`

## Requirements
- R1: While reset is asserted and right after it, every output of the block is low.
- R2: On a rising edge of `up_req` while idle, `hot_rst` rises one cycle later on every port whose `link_up` was high at that edge. It stays low on ports whose link was down.
- R3: A port's `hot_rst` stays high until `hr_ack` of that port is sampled high, or until it has been high for `hr_tmo`+1 cycles, whichever comes first. It falls one cycle after that.
- R4: In an upstream sequence, the step after the last `hot_rst` falls is a single-cycle `reg_rst` on all ports. Then `flush_req` goes to all ports. After every flush is done, a single-cycle `logic_rst` goes to all ports.
- R5: `flush_req` of a port stays high until `flush_done` of that port is sampled high. The sequence does not advance until no `flush_req` is high.
- R6: After its last step, a sequence waits until its control bit is sampled low and then goes idle. A request edge that arrives while busy is ignored, and a bit still high when idle is reached starts nothing.
- R7: A rising edge of `dn_req[i]` while idle resets port i only. The steps are a hot reset (if its link is up), then a flush, then a wait for `dn_req[i]` low. No `reg_rst` or `logic_rst` is issued, and no other port sees any output.
- R8: `ur_up` is high throughout an upstream sequence. `ur_dn[i]` is high throughout a downstream sequence of port i. Each flag runs from the cycle after the request edge up to and including the cycle in which the clear is sampled.
- R9: `sb_block` follows `ur_up`. While it is high, an access with `sb_tgt_rst` high sees `sb_rdata` = 0 and `sb_wr` = 0. Otherwise `sb_rdata` and `sb_wr` equal `sb_rdata_raw` and `sb_wr_raw`.
- R10: If an upstream edge and downstream edges arrive together, only the upstream sequence starts. If several downstream edges arrive together, only the lowest-numbered port is reset and the others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req | input | 1 | Upstream reset control bit |
| dn_req | input | NPORTS | Per-port downstream reset control bits |
| link_up | input | NPORTS | Per-port link-up status |
| hr_ack | input | NPORTS | Link-layer acknowledge of the hot reset |
| hr_tmo | input | TMO_W | Hot-reset timeout in cycles minus one |
| flush_done | input | NPORTS | Queue flush complete per port |
| sb_tgt_rst | input | 1 | Sideband access targets a resettable register |
| sb_rdata_raw | input | DW | Sideband read data from the register file |
| sb_wr_raw | input | 1 | Sideband write strobe from the interface |
| hot_rst | output | NPORTS | Hot-reset request to each link layer |
| reg_rst | output | NPORTS | Single-cycle soft reset of non-sticky registers |
| flush_req | output | NPORTS | Queue discard request |
| logic_rst | output | NPORTS | Single-cycle port logic reset |
| ur_up | output | 1 | Upstream bridge secondary side: unsupported request |
| ur_dn | output | NPORTS | Downstream bridge secondary side: unsupported request |
| sb_block | output | 1 | Sideband access to resettable registers is blocked |
| sb_rdata | output | DW | Filtered sideband read data |
| sb_wr | output | 1 | Filtered sideband write strobe |

## Verification
The bench covers the following corner cases, and what a faulty design would show in each:

- **Hot-reset timeout with no acknowledge.** A wrong count makes `hot_rst` one cycle too long or too short.
- **Port with its link down.** A design that wrongly signals a hot reset there is caught.
- **`flush_done` already high when the flush starts.** A design that drops the request in the same cycle is caught.
- **Simultaneous upstream and downstream edges.** A wrong priority lights `ur_dn`, or resets two ports at once.
- **Request bit held high, or re-pulsed, while a sequence runs.** A design that re-arms on level rather than edge starts a spurious second sequence.
- **Downstream sequences.** These must never emit register or logic resets, and must never mask sideband data.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HOT  = 3'd1,
    ST_REG  = 3'd2,
    ST_FLU  = 3'd3,
    ST_LOG  = 3'd4,
    ST_CLR  = 3'd5
  } sbr_state_e;
endpackage

// File: rtl/sbr_lane.sv
module sbr_lane #(
  parameter int TMO_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hr_start,
  input  logic             hr_ack,
  input  logic [TMO_W-1:0] tmo,
  input  logic             fl_start,
  input  logic             fl_done,
  output logic             hot_o,
  output logic             fl_o
);
  logic             hot_q, hot_d, hot_en;
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             fl_q, fl_d, fl_en;
  logic             hot_end;

  assign hot_end = hot_q && (hr_ack || (cnt_q == tmo));

  always_comb begin
    hot_en = hr_start || hot_end;
    hot_d  = hr_start;
    cnt_en = hr_start || (hot_q && !hot_end);
    cnt_d  = hr_start ? '0 : cnt_q + 1'b1;
    fl_en  = fl_start || (fl_q && fl_done);
    fl_d   = fl_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hot_q <= 1'b0;
      cnt_q <= '0;
      fl_q  <= 1'b0;
    end else begin
      if (hot_en) hot_q <= hot_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (fl_en)  fl_q  <= fl_d;
    end
  end

  assign hot_o = hot_q;
  assign fl_o  = fl_q;

  // R3
  hot_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_o && hr_ack && !hr_start) |=> !hot_o);

  // R5
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_o && !fl_done) |=> fl_o);
endmodule

// File: rtl/sbr_fsm.sv
module sbr_fsm
  import sbr_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req,
  input  logic [NPORTS-1:0] dn_req,
  input  logic [NPORTS-1:0] link_up,
  input  logic [NPORTS-1:0] hot_busy,
  input  logic [NPORTS-1:0] fl_busy,
  output logic [NPORTS-1:0] hr_start,
  output logic [NPORTS-1:0] fl_start,
  output logic [NPORTS-1:0] reg_rst,
  output logic [NPORTS-1:0] logic_rst,
  output logic              ur_up,
  output logic [NPORTS-1:0] ur_dn
);
  sbr_state_e        st_q, st_d;
  logic              kind_q, kind_d;
  logic [NPORTS-1:0] mask_q, mask_d;
  logic              up_prev_q;
  logic [NPORTS-1:0] dn_prev_q;
  logic              up_edge;
  logic [NPORTS-1:0] dn_edge, dn_pick;
  logic              launch, clr_seen, busy;

  assign up_edge  = up_req & ~up_prev_q;
  assign dn_edge  = dn_req & ~dn_prev_q;
  assign dn_pick  = dn_edge & (~dn_edge + 1'b1);
  assign clr_seen = kind_q ? !up_req : ((dn_req & mask_q) == '0);

  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    mask_d = mask_q;
    unique case (st_q)
      ST_IDLE: begin
        if (up_edge) begin
          st_d   = ST_HOT;
          kind_d = 1'b1;
          mask_d = '1;
        end else if (|dn_edge) begin
          st_d   = ST_HOT;
          kind_d = 1'b0;
          mask_d = dn_pick;
        end
      end
      ST_HOT: if (hot_busy == '0) st_d = kind_q ? ST_REG : ST_FLU;
      ST_REG: st_d = ST_FLU;
      ST_FLU: if (fl_busy == '0) st_d = kind_q ? ST_LOG : ST_CLR;
      ST_LOG: st_d = ST_CLR;
      ST_CLR: if (clr_seen) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign launch   = (st_q == ST_IDLE) && (st_d == ST_HOT);
  assign hr_start = launch ? (mask_d & link_up) : '0;
  assign fl_start = ((st_d == ST_FLU) && (st_q != ST_FLU)) ? mask_q : '0;
  assign reg_rst  = (st_q == ST_REG) ? mask_q : '0;
  assign logic_rst = (st_q == ST_LOG) ? mask_q : '0;
  assign busy     = (st_q != ST_IDLE);
  assign ur_up    = busy && kind_q;
  assign ur_dn    = (busy && !kind_q) ? mask_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      kind_q    <= 1'b0;
      mask_q    <= '0;
      up_prev_q <= 1'b0;
      dn_prev_q <= '0;
    end else begin
      st_q      <= st_d;
      up_prev_q <= up_req;
      dn_prev_q <= dn_req;
      if (launch) begin
        kind_q <= kind_d;
        mask_q <= mask_d;
      end
    end
  end

  // R7
  dn_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ur_dn));

  // R10
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ur_up && (ur_dn != '0)));
endmodule

// File: rtl/sbr_sb_gate.sv
module sbr_sb_gate #(
  parameter int DW = 8
) (
  input  logic          blk,
  input  logic          tgt,
  input  logic [DW-1:0] rd_raw,
  input  logic          wr_raw,
  output logic [DW-1:0] rd_out,
  output logic          wr_out
);
  logic mask_on;

  always_comb begin
    mask_on = blk && tgt;
    rd_out  = mask_on ? '0 : rd_raw;
    wr_out  = wr_raw && !mask_on;
  end
endmodule

// File: rtl/sbr_seq.sv
module sbr_seq #(
  parameter int NPORTS = 4,
  parameter int TMO_W  = 4,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_req,
  input  logic [NPORTS-1:0] dn_req,
  input  logic [NPORTS-1:0] link_up,
  input  logic [NPORTS-1:0] hr_ack,
  input  logic [TMO_W-1:0]  hr_tmo,
  input  logic [NPORTS-1:0] flush_done,
  input  logic              sb_tgt_rst,
  input  logic [DW-1:0]     sb_rdata_raw,
  input  logic              sb_wr_raw,
  output logic [NPORTS-1:0] hot_rst,
  output logic [NPORTS-1:0] reg_rst,
  output logic [NPORTS-1:0] flush_req,
  output logic [NPORTS-1:0] logic_rst,
  output logic              ur_up,
  output logic [NPORTS-1:0] ur_dn,
  output logic              sb_block,
  output logic [DW-1:0]     sb_rdata,
  output logic              sb_wr
);
  logic [1:0]        sync_q;
  logic              srst_n;
  logic [NPORTS-1:0] hr_start, fl_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign srst_n = sync_q[1];

  sbr_fsm #(.NPORTS(NPORTS)) fsm_i (
    .clk       (clk),
    .rst_n     (srst_n),
    .up_req    (up_req),
    .dn_req    (dn_req),
    .link_up   (link_up),
    .hot_busy  (hot_rst),
    .fl_busy   (flush_req),
    .hr_start  (hr_start),
    .fl_start  (fl_start),
    .reg_rst   (reg_rst),
    .logic_rst (logic_rst),
    .ur_up     (ur_up),
    .ur_dn     (ur_dn)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_lane
    sbr_lane #(.TMO_W(TMO_W)) lane_i (
      .clk      (clk),
      .rst_n    (srst_n),
      .hr_start (hr_start[p]),
      .hr_ack   (hr_ack[p]),
      .tmo      (hr_tmo),
      .fl_start (fl_start[p]),
      .fl_done  (flush_done[p]),
      .hot_o    (hot_rst[p]),
      .fl_o     (flush_req[p])
    );
  end

  assign sb_block = ur_up;

  sbr_sb_gate #(.DW(DW)) gate_i (
    .blk    (sb_block),
    .tgt    (sb_tgt_rst),
    .rd_raw (sb_rdata_raw),
    .wr_raw (sb_wr_raw),
    .rd_out (sb_rdata),
    .wr_out (sb_wr)
  );

  // R4
  reg_then_flush_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (reg_rst != '0) |=> (flush_req == $past(reg_rst)));

  // R8
  hot_ur_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (hot_rst != '0) |-> (ur_up || (ur_dn != '0)));

  // R9
  sb_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (sb_block && sb_tgt_rst) |-> ((sb_rdata == '0) && !sb_wr));

  // R7
  dn_no_reg_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (ur_dn != '0) |-> ((reg_rst == '0) && (logic_rst == '0)));
endmodule

// File: tb/sbr_seq_tb_top.sv
module sbr_seq_tb_top;
  localparam int N  = 4;
  localparam int TW = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic up_req;
  logic [N-1:0] dn_req, link_up, hr_ack, flush_done;
  logic [TW-1:0] hr_tmo;
  logic sb_tgt_rst, sb_wr_raw;
  logic [DW-1:0] sb_rdata_raw;
  logic [N-1:0] hot_rst, reg_rst, flush_req, logic_rst, ur_dn;
  logic ur_up, sb_block, sb_wr;
  logic [DW-1:0] sb_rdata;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  sbr_seq #(.NPORTS(N), .TMO_W(TW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .dn_req(dn_req),
    .link_up(link_up), .hr_ack(hr_ack), .hr_tmo(hr_tmo),
    .flush_done(flush_done), .sb_tgt_rst(sb_tgt_rst),
    .sb_rdata_raw(sb_rdata_raw), .sb_wr_raw(sb_wr_raw),
    .hot_rst(hot_rst), .reg_rst(reg_rst), .flush_req(flush_req),
    .logic_rst(logic_rst), .ur_up(ur_up), .ur_dn(ur_dn),
    .sb_block(sb_block), .sb_rdata(sb_rdata), .sb_wr(sb_wr)
  );

  // staged stimulus
  logic s_up;
  logic [N-1:0] s_dn, s_link, s_ack, s_done;
  logic [TW-1:0] s_tmo;
  logic s_tgt, s_wr;
  logic [DW-1:0] s_rd;

  // reference model: 0 idle,1 hot,2 reg,3 flush,4 logic,5 clear
  int m_st;
  bit m_up_kind;
  logic [N-1:0] m_mask, m_hot, m_fl, m_pdn;
  bit m_pup;
  int m_cnt [N];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] exp_reg();
    return (m_st == 2) ? m_mask : '0;
  endfunction
  function automatic logic [N-1:0] exp_log();
    return (m_st == 4) ? m_mask : '0;
  endfunction
  function automatic bit exp_urup();
    return (m_st != 0) && m_up_kind;
  endfunction
  function automatic logic [N-1:0] exp_urdn();
    return ((m_st != 0) && !m_up_kind) ? m_mask : '0;
  endfunction

  task automatic model_step();
    int nst;
    bit nk;
    logic [N-1:0] nm, hs, fs, ue_dn, pick;
    bit ue;
    nst = m_st; nk = m_up_kind; nm = m_mask; hs = '0; fs = '0;
    ue = s_up && !m_pup;
    ue_dn = s_dn & ~m_pdn;
    case (m_st)
      0: if (ue) begin
           nst = 1; nk = 1; nm = '1; hs = nm & s_link;
         end else if (ue_dn != '0) begin
           pick = '0;
           for (int i = N - 1; i >= 0; i--) if (ue_dn[i]) pick = N'(1) << i;
           nst = 1; nk = 0; nm = pick; hs = pick & s_link;
         end
      1: if (m_hot == '0) begin
           nst = m_up_kind ? 2 : 3;
           if (!m_up_kind) fs = m_mask;
         end
      2: begin nst = 3; fs = m_mask; end
      3: if (m_fl == '0) nst = m_up_kind ? 4 : 5;
      4: nst = 5;
      5: if (m_up_kind ? !s_up : ((s_dn & m_mask) == '0)) nst = 0;
      default: nst = 0;
    endcase
    for (int i = 0; i < N; i++) begin
      if (m_hot[i]) begin
        if (s_ack[i] || (m_cnt[i] == int'(s_tmo))) m_hot[i] = 1'b0;
        else m_cnt[i] = m_cnt[i] + 1;
      end
      if (hs[i]) begin m_hot[i] = 1'b1; m_cnt[i] = 0; end
      if (m_fl[i] && s_done[i]) m_fl[i] = 1'b0;
      if (fs[i]) m_fl[i] = 1'b1;
    end
    m_st = nst; m_up_kind = nk; m_mask = nm;
    m_pup = s_up; m_pdn = s_dn;
  endtask

  task automatic cyc();
    bit blkx;
    @(negedge clk);
    chk(hot_rst == m_hot, "R2 R3 hot_rst", int'(hot_rst), int'(m_hot));
    chk(flush_req == m_fl, "R5 flush_req", int'(flush_req), int'(m_fl));
    chk(reg_rst == exp_reg(), "R4 reg_rst", int'(reg_rst), int'(exp_reg()));
    chk(logic_rst == exp_log(), "R4 logic_rst", int'(logic_rst), int'(exp_log()));
    chk(ur_up == exp_urup(), "R8 ur_up", int'(ur_up), int'(exp_urup()));
    chk(ur_dn == exp_urdn(), "R7 R8 ur_dn", int'(ur_dn), int'(exp_urdn()));
    chk(sb_block == exp_urup(), "R9 sb_block", int'(sb_block), int'(exp_urup()));
    up_req = s_up; dn_req = s_dn; link_up = s_link; hr_ack = s_ack;
    flush_done = s_done; hr_tmo = s_tmo; sb_tgt_rst = s_tgt;
    sb_wr_raw = s_wr; sb_rdata_raw = s_rd;
    #1;
    blkx = exp_urup() && s_tgt;
    chk(sb_rdata == (blkx ? '0 : s_rd), "R9 sb_rdata", int'(sb_rdata),
        int'(blkx ? '0 : s_rd));
    chk(sb_wr == (s_wr && !blkx), "R9 sb_wr", int'(sb_wr), int'(s_wr && !blkx));
    model_step();
  endtask

  task automatic settle(input int n);
    s_up = 0; s_dn = '0; s_ack = '1; s_done = '1;
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 0; up_req = 0; dn_req = '0; link_up = '0; hr_ack = '0;
    flush_done = '0; hr_tmo = '0; sb_tgt_rst = 0; sb_wr_raw = 0; sb_rdata_raw = '0;
    s_up = 0; s_dn = '0; s_link = '0; s_ack = '0; s_done = '0; s_tmo = '0;
    s_tgt = 0; s_wr = 0; s_rd = '0;
    m_st = 0; m_up_kind = 0; m_mask = '0; m_hot = '0; m_fl = '0;
    m_pdn = '0; m_pup = 0;
    for (int i = 0; i < N; i++) m_cnt[i] = 0;
    repeat (4) @(negedge clk);
    // R1
    chk({hot_rst, reg_rst, flush_req, logic_rst, ur_dn, ur_up, sb_block} == '0,
        "R1 reset outputs", int'({hot_rst, flush_req, ur_dn}), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk({hot_rst, reg_rst, flush_req, logic_rst, ur_dn, ur_up, sb_block} == '0,
        "R1 after release", int'({hot_rst, flush_req, ur_dn}), 0);

    // R3 timeout, R2 link-down skip: no ack, tmo=2, links 0101
    s_link = 4'b0101; s_ack = '0; s_done = '0; s_tmo = 4'd2; s_tgt = 1; s_rd = 8'hA5; s_wr = 1;
    cyc();
    s_up = 1; cyc();
    cyc();
    chk(hot_rst == 4'b0101, "R2 hot on linked ports", int'(hot_rst), 5);
    for (int i = 0; i < 6; i++) cyc();
    s_done = 4'b0011; cyc(); cyc();
    s_done = '1; for (int i = 0; i < 6; i++) cyc();
    chk(ur_up == 1'b1, "R6 waits for clear", int'(ur_up), 1);
    settle(8);

    // R10 simultaneous upstream and downstream edges
    s_up = 1; s_dn = 4'b0110; s_link = '1; cyc();
    cyc();
    chk(ur_up == 1'b1 && ur_dn == '0, "R10 upstream wins", int'(ur_dn), 0);
    settle(20);

    // R10 lowest downstream port; R6 upstream edge while busy ignored
    s_ack = '0; s_done = '0; s_tmo = 4'd5;
    s_dn = 4'b0110; cyc();
    cyc();
    chk(ur_dn == 4'b0010, "R10 lowest port", int'(ur_dn), 2);
    chk(hot_rst == 4'b0010, "R7 only target port", int'(hot_rst), 2);
    s_up = 1; cyc(); cyc();
    s_ack = '1; s_done = 4'b0010; for (int i = 0; i < 4; i++) cyc();
    s_dn = '0; for (int i = 0; i < 6; i++) cyc();
    chk(ur_up == 1'b0 && ur_dn == '0, "R6 no restart on held bit", int'(ur_up), 0);
    s_up = 0;
    settle(8);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      if (($urandom % 20) == 0) s_up = ~s_up;
      for (int i = 0; i < N; i++) begin
        if (($urandom % 16) == 0) s_dn[i] = ~s_dn[i];
        if (($urandom % 40) == 0) s_link[i] = ~s_link[i];
        s_ack[i]  = (($urandom % 4) == 0);
        s_done[i] = (($urandom % 3) == 0);
      end
      if (($urandom % 50) == 0) s_tmo = TW'($urandom % 7);
      s_tgt = $urandom % 2;
      s_wr  = $urandom % 2;
      s_rd  = DW'($urandom);
      cyc();
    end
    settle(10);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule